// File: doc/BRIEF.md
# Lockstep / Split Mode Switch Controller

This controller moves a pair of processor cores between two operating modes. In safety mode both cores run one program with a fixed time offset, and a comparator checks their outputs. In performance mode each core runs its own program, and both reach memory directly. Each core signals the controller with a one-cycle request pulse when it executes the mode-change instruction. A target bit sent with the pulse names the mode the core is asking for. The controller answers with a halt line per core, an interrupt line per core, a clock-realignment strobe, a mode output and an error pulse. The mode output is meant to enable the comparator and the time offset, and to select how the cores are routed to memory.

Leaving safety mode, both cores reach the instruction and are held. The clocks are then realigned and the mode flips to performance. The cores then read a core-identity bit, which differs between them only in performance mode, and branch apart on it. Returning to safety mode, the first core to ask is held and the other core is interrupted. That core saves its context and executes the same instruction. When its request arrives the mode flips back to safety. The first core is released at once and the second is released after the lockstep offset. If a partner core never reaches its request within a configured window, an error pulse is raised and both cores are released in the old mode.

Top module: `mode_switch_ctrl`

## Requirements
- R1: After reset the mode output is 0 (safety), and every halt line, interrupt line, the align strobe and the error pulse are 0.
- R2: In safety mode, a request with target bit 1 (performance) halts the requesting core from the next cycle. A later such request from the other core halts both cores and raises the align strobe for ALIGN_CYC cycles. After that, the mode output becomes 1, both halts drop and the align strobe drops, all on the same edge.
- R3: In performance mode, a request with target bit 0 (safety) from one core halts that core from the next cycle. In the same cycle the interrupt line of the other core goes high, for exactly one cycle.
- R4: A target-0 request from the second core, while the first core is held, sets the mode output to 0 and releases the first core on the same edge. It keeps the second core halted for OFFSET_CYC cycles and releases it on the following edge. The align strobe is high for those OFFSET_CYC cycles.
- R5: The mode output changes only on the edge that ends the alignment phase (to 1) or on the edge that starts the staggered resume (to 0).
- R6: The identity output is id_sel ANDed with the mode output. In performance mode core A (id_sel=0) reads 0 and core B (id_sel=1) reads 1; in safety mode both read 0.
- R7: If the partner request does not arrive within TIMEOUT_CYC cycles of the first accepted request, the error output pulses high for one cycle. On that same edge both halts drop and the mode output keeps its old value.
- R8: Requests that arrive during alignment or staggered resume, and a repeated request from the core already holding, have no effect.
- R9: A request whose target bit equals the current mode output has no effect.
- R10: Target-matching requests from both cores in the same cycle skip the wait. From safety this goes straight to alignment with both cores halted. From performance it goes straight to the staggered resume, with core A released first and core B held, and with no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_a | input | 1 | Switch request pulse from core A |
| tgt_a | input | 1 | Target mode of core A's request, 1 = performance |
| req_b | input | 1 | Switch request pulse from core B |
| tgt_b | input | 1 | Target mode of core B's request, 1 = performance |
| id_sel | input | 1 | Which core reads the identity bit, 0 = A, 1 = B |
| halt_a | output | 1 | Hold core A |
| halt_b | output | 1 | Hold core B |
| irq_a | output | 1 | Switch interrupt to core A |
| irq_b | output | 1 | Switch interrupt to core B |
| clk_align | output | 1 | Clock realignment strobe |
| perf_mode | output | 1 | 1 = performance mode, 0 = safety mode |
| id_bit | output | 1 | Core identity bit for software branching |
| switch_err | output | 1 | One-cycle pulse on partner timeout |

## Verification
A wrong internal state shows at the ports within one cycle, because every output is a register written from the state. A lost or extra phase leaves a halt line wrong, or moves the mode flip by at least one edge. A miscounted window moves the release of the align strobe, the stagger release or the error pulse by whole cycles. A behavioural model in the bench tracks the expected halts, interrupts, strobe, mode and error on every cycle, so any such slip is seen on the cycle it happens. Directed sequences hit the timeout edge, simultaneous requests and ignored requests in each phase.

// File: rtl/msw_pkg.sv
package msw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE_SAFE      = 3'd0,
        ST_WAIT_BOTH      = 3'd1,
        ST_ALIGN          = 3'd2,
        ST_PERF           = 3'd3,
        ST_HALT1_IRQ2     = 3'd4,
        ST_WAIT2          = 3'd5,
        ST_RESUME_STAGGER = 3'd6
    } msw_state_e;

    localparam int unsigned NCORE = 2;
    localparam int unsigned CORE_A = 0;
    localparam int unsigned CORE_B = 1;
endpackage

// File: rtl/msw_req_qual.sv
module msw_req_qual
    import msw_pkg::*;
(
    input  logic [NCORE-1:0] req,
    input  logic [NCORE-1:0] tgt,
    output logic [NCORE-1:0] want_perf,
    output logic [NCORE-1:0] want_safe
);
    // split each request pulse by the mode it asks for
    for (genvar g = 0; g < NCORE; g++) begin : g_core
        assign want_perf[g] = req[g] &  tgt[g];
        assign want_safe[g] = req[g] & ~tgt[g];
    end
endmodule

// File: rtl/msw_fsm.sv
module msw_fsm
    import msw_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 1000,
    parameter int unsigned ALIGN_CYC   = 2,
    parameter int unsigned OFFSET_CYC  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCORE-1:0] want_perf,
    input  logic [NCORE-1:0] want_safe,
    output logic             halt_a,
    output logic             halt_b,
    output logic             irq_a,
    output logic             irq_b,
    output logic             clk_align,
    output logic             perf_mode,
    output logic             switch_err
);
    localparam int unsigned MAX_A  = (ALIGN_CYC > OFFSET_CYC) ? ALIGN_CYC : OFFSET_CYC;
    localparam int unsigned MAX_W  = (TIMEOUT_CYC > MAX_A) ? TIMEOUT_CYC : MAX_A;
    localparam int unsigned CW     = $clog2(MAX_W + 1);
    localparam logic [CW-1:0] TO_LAST  = CW'(TIMEOUT_CYC - 1);
    localparam logic [CW-1:0] AL_LAST  = CW'(ALIGN_CYC - 1);
    localparam logic [CW-1:0] OF_LAST  = CW'(OFFSET_CYC - 1);

    typedef struct packed {
        msw_state_e    st;
        logic          first_b;
        logic          mode_perf;
        logic          halt_a;
        logic          halt_b;
        logic          irq_a;
        logic          irq_b;
        logic          align;
        logic          err;
        logic [CW-1:0] cnt;
    } ctrl_s;

    localparam ctrl_s RESET_VAL = '{st: ST_IDLE_SAFE, first_b: 1'b0, mode_perf: 1'b0,
                                    halt_a: 1'b0, halt_b: 1'b0, irq_a: 1'b0, irq_b: 1'b0,
                                    align: 1'b0, err: 1'b0, cnt: '0};

    ctrl_s ctrl_d, ctrl_q;
    logic  partner_perf, partner_safe;

    always_comb begin
        partner_perf = ctrl_q.first_b ? want_perf[CORE_A] : want_perf[CORE_B];
        partner_safe = ctrl_q.first_b ? want_safe[CORE_A] : want_safe[CORE_B];
        ctrl_d       = ctrl_q;
        ctrl_d.err   = 1'b0;
        ctrl_d.irq_a = 1'b0;
        ctrl_d.irq_b = 1'b0;
        unique case (ctrl_q.st)
            ST_IDLE_SAFE: begin
                if (want_perf[CORE_A] && want_perf[CORE_B]) begin
                    ctrl_d.st     = ST_ALIGN;
                    ctrl_d.halt_a = 1'b1;
                    ctrl_d.halt_b = 1'b1;
                    ctrl_d.align  = 1'b1;
                    ctrl_d.cnt    = '0;
                end else if (want_perf[CORE_A] || want_perf[CORE_B]) begin
                    ctrl_d.st      = ST_WAIT_BOTH;
                    ctrl_d.first_b = want_perf[CORE_B];
                    ctrl_d.halt_a  = want_perf[CORE_A];
                    ctrl_d.halt_b  = want_perf[CORE_B];
                    ctrl_d.cnt     = '0;
                end
            end
            ST_WAIT_BOTH: begin
                if (partner_perf) begin
                    ctrl_d.st     = ST_ALIGN;
                    ctrl_d.halt_a = 1'b1;
                    ctrl_d.halt_b = 1'b1;
                    ctrl_d.align  = 1'b1;
                    ctrl_d.cnt    = '0;
                end else if (ctrl_q.cnt == TO_LAST) begin
                    ctrl_d.st     = ST_IDLE_SAFE;
                    ctrl_d.halt_a = 1'b0;
                    ctrl_d.halt_b = 1'b0;
                    ctrl_d.err    = 1'b1;
                end else begin
                    ctrl_d.cnt = ctrl_q.cnt + 1'b1;
                end
            end
            ST_ALIGN: begin
                if (ctrl_q.cnt == AL_LAST) begin
                    ctrl_d.st        = ST_PERF;
                    ctrl_d.mode_perf = 1'b1;
                    ctrl_d.halt_a    = 1'b0;
                    ctrl_d.halt_b    = 1'b0;
                    ctrl_d.align     = 1'b0;
                end else begin
                    ctrl_d.cnt = ctrl_q.cnt + 1'b1;
                end
            end
            ST_PERF: begin
                if (want_safe[CORE_A] && want_safe[CORE_B]) begin
                    ctrl_d.st        = ST_RESUME_STAGGER;
                    ctrl_d.mode_perf = 1'b0;
                    ctrl_d.first_b   = 1'b0;
                    ctrl_d.halt_a    = 1'b0;
                    ctrl_d.halt_b    = 1'b1;
                    ctrl_d.align     = 1'b1;
                    ctrl_d.cnt       = '0;
                end else if (want_safe[CORE_A] || want_safe[CORE_B]) begin
                    ctrl_d.st      = ST_HALT1_IRQ2;
                    ctrl_d.first_b = want_safe[CORE_B];
                    ctrl_d.halt_a  = want_safe[CORE_A];
                    ctrl_d.halt_b  = want_safe[CORE_B];
                    ctrl_d.irq_b   = want_safe[CORE_A];
                    ctrl_d.irq_a   = want_safe[CORE_B];
                    ctrl_d.cnt     = '0;
                end
            end
            ST_HALT1_IRQ2, ST_WAIT2: begin
                if (partner_safe) begin
                    ctrl_d.st        = ST_RESUME_STAGGER;
                    ctrl_d.mode_perf = 1'b0;
                    ctrl_d.halt_a    = ctrl_q.first_b;
                    ctrl_d.halt_b    = ~ctrl_q.first_b;
                    ctrl_d.align     = 1'b1;
                    ctrl_d.cnt       = '0;
                end else if (ctrl_q.cnt == TO_LAST) begin
                    ctrl_d.st     = ST_PERF;
                    ctrl_d.halt_a = 1'b0;
                    ctrl_d.halt_b = 1'b0;
                    ctrl_d.err    = 1'b1;
                end else begin
                    ctrl_d.st  = ST_WAIT2;
                    ctrl_d.cnt = ctrl_q.cnt + 1'b1;
                end
            end
            ST_RESUME_STAGGER: begin
                if (ctrl_q.cnt == OF_LAST) begin
                    ctrl_d.st     = ST_IDLE_SAFE;
                    ctrl_d.halt_a = 1'b0;
                    ctrl_d.halt_b = 1'b0;
                    ctrl_d.align  = 1'b0;
                end else begin
                    ctrl_d.cnt = ctrl_q.cnt + 1'b1;
                end
            end
            default: ctrl_d = RESET_VAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= RESET_VAL;
        else        ctrl_q <= ctrl_d;
    end

    assign halt_a     = ctrl_q.halt_a;
    assign halt_b     = ctrl_q.halt_b;
    assign irq_a      = ctrl_q.irq_a;
    assign irq_b      = ctrl_q.irq_b;
    assign clk_align  = ctrl_q.align;
    assign perf_mode  = ctrl_q.mode_perf;
    assign switch_err = ctrl_q.err;

    assert_perf_unhalted_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.st == ST_PERF) |-> (!ctrl_q.halt_a && !ctrl_q.halt_b));

    assert_irq_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.irq_a || ctrl_q.irq_b) |=> !(ctrl_q.irq_a || ctrl_q.irq_b));

    assert_stagger_one_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.st == ST_RESUME_STAGGER) |-> ((ctrl_q.halt_a != ctrl_q.halt_b) && ctrl_q.align));

    assert_mode_flip_points_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.mode_perf != $past(ctrl_q.mode_perf)) |->
        ((ctrl_q.mode_perf && $past(ctrl_q.st) == ST_ALIGN) ||
         (!ctrl_q.mode_perf && ctrl_q.st == ST_RESUME_STAGGER)));

    assert_err_from_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.err |-> ($past(ctrl_q.st) == ST_WAIT_BOTH || $past(ctrl_q.st) == ST_WAIT2 ||
                        $past(ctrl_q.st) == ST_HALT1_IRQ2));
endmodule

// File: rtl/mode_switch_ctrl.sv
module mode_switch_ctrl
    import msw_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 1000,
    parameter int unsigned ALIGN_CYC   = 2,
    parameter int unsigned OFFSET_CYC  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_a,
    input  logic tgt_a,
    input  logic req_b,
    input  logic tgt_b,
    input  logic id_sel,
    output logic halt_a,
    output logic halt_b,
    output logic irq_a,
    output logic irq_b,
    output logic clk_align,
    output logic perf_mode,
    output logic id_bit,
    output logic switch_err
);
    logic [NCORE-1:0] want_perf, want_safe;

    msw_req_qual u_qual (
        .req       ({req_b, req_a}),
        .tgt       ({tgt_b, tgt_a}),
        .want_perf (want_perf),
        .want_safe (want_safe)
    );

    msw_fsm #(
        .TIMEOUT_CYC (TIMEOUT_CYC),
        .ALIGN_CYC   (ALIGN_CYC),
        .OFFSET_CYC  (OFFSET_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .want_perf  (want_perf),
        .want_safe  (want_safe),
        .halt_a     (halt_a),
        .halt_b     (halt_b),
        .irq_a      (irq_a),
        .irq_b      (irq_b),
        .clk_align  (clk_align),
        .perf_mode  (perf_mode),
        .switch_err (switch_err)
    );

    // identity differs only once the cores run separately (R6)
    assign id_bit = id_sel & perf_mode;

    assert_id_safe_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !perf_mode |-> !id_bit);
endmodule

// File: tb/mode_switch_ctrl_tb.sv
module mode_switch_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TO  = 20;
    localparam int AL  = 2;
    localparam int OF  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_a = 0, tgt_a = 0, req_b = 0, tgt_b = 0, id_sel = 0;
    logic halt_a, halt_b, irq_a, irq_b, clk_align, perf_mode, id_bit, switch_err;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mode_switch_ctrl #(.TIMEOUT_CYC(TO), .ALIGN_CYC(AL), .OFFSET_CYC(OF)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_a(req_a), .tgt_a(tgt_a), .req_b(req_b), .tgt_b(tgt_b),
        .id_sel(id_sel), .halt_a(halt_a), .halt_b(halt_b), .irq_a(irq_a), .irq_b(irq_b),
        .clk_align(clk_align), .perf_mode(perf_mode), .id_bit(id_bit), .switch_err(switch_err));

    // behavioural reference: phase names are strings, timers are integers
    string ph = "safe";
    int    tmr = 0;
    int    holder = 0;        // 0: core A asked first, 1: core B
    bit    e_perf, e_ha, e_hb, e_ia, e_ib, e_al, e_err;

    task automatic chk(input string tag, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        bit pa, pb, sa, sb, cur_perf;
        pa = req_a & tgt_a;  pb = req_b & tgt_b;
        sa = req_a & ~tgt_a; sb = req_b & ~tgt_b;
        e_err = 0; e_ia = 0; e_ib = 0;
        if (!rst_n) begin
            ph = "safe"; tmr = 0; e_perf = 0; e_ha = 0; e_hb = 0; e_al = 0;
        end else if (ph == "safe") begin
            if (pa && pb) begin ph = "align"; tmr = AL; e_ha = 1; e_hb = 1; e_al = 1; end
            else if (pa || pb) begin ph = "pair"; tmr = TO; holder = pb; e_ha = pa; e_hb = pb; end
        end else if (ph == "pair") begin
            tmr--;
            if ((holder == 0) ? pb : pa) begin ph = "align"; tmr = AL; e_ha = 1; e_hb = 1; e_al = 1; end
            else if (tmr == 0) begin ph = "safe"; e_ha = 0; e_hb = 0; e_err = 1; end
        end else if (ph == "align") begin
            tmr--;
            if (tmr == 0) begin ph = "perf"; e_perf = 1; e_ha = 0; e_hb = 0; e_al = 0; end
        end else if (ph == "perf") begin
            if (sa && sb) begin ph = "stagger"; tmr = OF; e_perf = 0; e_ha = 0; e_hb = 1; e_al = 1; end
            else if (sa || sb) begin
                ph = "partner"; tmr = TO; holder = sb; e_ha = sa; e_hb = sb; e_ib = sa; e_ia = sb;
            end
        end else if (ph == "partner") begin
            tmr--;
            if ((holder == 0) ? sb : sa) begin
                ph = "stagger"; tmr = OF; e_perf = 0; e_ha = (holder == 1); e_hb = (holder == 0); e_al = 1;
            end else if (tmr == 0) begin ph = "perf"; e_ha = 0; e_hb = 0; e_err = 1; end
        end else if (ph == "stagger") begin
            tmr--;
            if (tmr == 0) begin ph = "safe"; e_ha = 0; e_hb = 0; e_al = 0; end
        end
        cur_perf = e_perf;
        #2;
        if (rst_n && !done) begin
            chk("model halt_a R2", halt_a, e_ha);
            chk("model halt_b R4", halt_b, e_hb);
            chk("model irq_a R3", irq_a, e_ia);
            chk("model irq_b R3", irq_b, e_ib);
            chk("model clk_align R2", clk_align, e_al);
            chk("model perf_mode R5", perf_mode, cur_perf);
            chk("model id_bit R6", id_bit, id_sel & cur_perf);
            chk("model switch_err R7", switch_err, e_err);
        end
    end

    task automatic pulse(input bit a, input bit ta, input bit b, input bit tb);
        @(negedge clk);
        req_a = a; tgt_a = ta; req_b = b; tgt_b = tb;
        @(negedge clk);
        req_a = 0; req_b = 0;
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        wait_neg(3);
        chk("R1 reset perf_mode", perf_mode, 0);
        chk("R1 reset halt_a", halt_a, 0);
        chk("R1 reset clk_align", clk_align, 0);
        rst_n = 1;
        wait_neg(2);
        chk("R1 after release halt_b", halt_b, 0);
        id_sel = 1;
        #1 chk("R6 safety id", id_bit, 0);

        pulse(1, 0, 0, 0);                         // target equals current mode
        chk("R9 safe-to-safe ignored", halt_a, 0);

        pulse(1, 1, 0, 0);
        chk("R2 first halt", halt_a, 1);
        chk("R2 other free", halt_b, 0);
        pulse(1, 1, 0, 0);                         // repeat from holder
        chk("R8 repeat holder ignored", clk_align, 0);
        pulse(0, 0, 1, 1);
        chk("R2 align raised", clk_align, 1);
        chk("R2 both halted", halt_b, 1);
        wait_neg(1);
        chk("R5 mode held during align", perf_mode, 0);
        wait_neg(1);
        chk("R2 mode perf", perf_mode, 1);
        chk("R2 halts released", halt_a, 0);
        chk("R6 perf id core B", id_bit, 1);
        id_sel = 0;
        #1 chk("R6 perf id core A", id_bit, 0);

        pulse(1, 1, 0, 0);
        chk("R9 perf-to-perf ignored", halt_a, 0);

        pulse(0, 0, 1, 0);                         // core B first
        chk("R3 holder halted", halt_b, 1);
        chk("R3 irq to A", irq_a, 1);
        wait_neg(1);
        chk("R3 irq one cycle", irq_a, 0);
        pulse(0, 0, 1, 0);
        chk("R8 repeat holder perf", perf_mode, 1);
        pulse(1, 0, 0, 0);
        chk("R4 mode safety", perf_mode, 0);
        chk("R4 first released", halt_b, 0);
        chk("R4 second held", halt_a, 1);
        pulse(1, 1, 0, 0);                         // during stagger
        chk("R8 stagger ignored", halt_a, 1);
        chk("R4 align during stagger", clk_align, 1);
        wait_neg(1);
        chk("R4 second released", halt_a, 0);
        wait_neg(1);
        chk("R8 no late start", halt_a, 0);

        pulse(1, 1, 0, 0);
        wait_neg(TO - 1);
        chk("R7 still waiting", halt_a, 1);
        chk("R7 no early error", switch_err, 0);
        wait_neg(1);
        chk("R7 error pulse", switch_err, 1);
        chk("R7 released", halt_a, 0);
        chk("R7 mode kept", perf_mode, 0);
        wait_neg(1);
        chk("R7 error one cycle", switch_err, 0);

        pulse(1, 1, 1, 1);
        chk("R10 direct align", clk_align, 1);
        chk("R10 both halted", halt_a & halt_b, 1);
        wait_neg(AL);
        chk("R10 in perf", perf_mode, 1);

        pulse(1, 0, 0, 0);
        wait_neg(TO);
        chk("R7 perf timeout error", switch_err, 1);
        chk("R7 perf mode kept", perf_mode, 1);

        pulse(1, 0, 1, 0);
        chk("R10 direct stagger mode", perf_mode, 0);
        chk("R10 A released first", halt_a, 0);
        chk("R10 B held", halt_b, 1);
        chk("R10 no irq", irq_a | irq_b, 0);
        wait_neg(OF + 2);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule